// File: doc/BRIEF.md
# Grouped Unsigned-Integer to Single-Precision Vector Converter

This unit decodes and carries out a single vector instruction that turns 32-bit unsigned integer lanes into IEEE-754 single-precision values. One instruction names an aligned group of either two or four consecutive vector registers as the source and another aligned group of the same size as the destination. Every lane of every source register is converted, and each result lands in the same lane position of the matching destination register. The instruction has no predicate, so no lane is skipped.

The unit contains its own vector register file, whose vector length is a parameter. The register file has one external write port and one combinational read port. A one-cycle `start` pulse hands over the instruction word, the 2-bit rounding mode and a feature-enable level. The unit then converts one lane per cycle into an internal result buffer. Only after every lane of the group has been converted does it write the destination registers back, one per cycle, so a destination group that overlaps the source group still produces correct results. An instruction that is not enabled, or that matches neither encoding, finishes at once with an illegal flag and changes no register.

Top module: `ucvt_group_unit`

## Requirements
- R1: Pair form. The instruction matches when bits 31..10 = 1100000100100010111000, bit 5 = 1 and bit 0 = 0. Bits 9..6 times 2 give the first source register and bits 4..1 times 2 give the first destination register. Source registers s and s+1 are converted into destination registers d and d+1.
- R2: Quad form. The instruction matches when bits 31..10 = 1100000100110010111000, bits 6..5 = 01 and bits 1..0 = 00. Bits 9..7 times 4 give the first source register and bits 4..2 times 4 give the first destination register. Registers s..s+3 are converted into d..d+3.
- R3: Each lane is read as an unsigned integer with no fraction bits. The result sign bit is always 0, zero converts to 32'h00000000, and any value below 2^24 converts exactly.
- R4: The rounding-mode input selects how inexact values are rounded: 00 nearest with ties to even, 01 toward plus infinity, 10 toward minus infinity, 11 toward zero. Halfway cases follow these rules, and 32'hFFFFFFFF rounds to 32'h4F800000 under 00 and 01 and to 32'h4F7FFFFF under 10 and 11.
- R5: The rounding mode is captured in the cycle the instruction is accepted. Changing the input while the unit is busy does not affect the results.
- R6: Every one of the VLEN/32 lanes of every register in the group is converted, and lane i of a source register goes to lane i of its destination register, where lane i occupies bits 32*i+31..32*i.
- R7: All lanes of the group are converted before the first destination write, so a destination group equal to the source group yields the conversion of the original contents.
- R8: When feature enable is low at acceptance, the instruction completes with `illegal` high and no register is modified.
- R9: An instruction word that matches neither form completes with `illegal` high and no register is modified.
- R10: After reset `busy`, `done` and `illegal` are low and all registers read zero. `start` is accepted only while idle. A legal instruction raises `done` for one cycle exactly n*(VLEN/32)+n cycles after acceptance, where n is the group size, and an illegal one raises it one cycle after acceptance. `busy` is high in between. `start` and the instruction word are ignored while busy.
- R11: Registers outside the destination group keep their contents. The external write port takes effect only while the unit is not busy, and the read port returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Offer the instruction on `instr` |
| instr | input | 32 | Instruction word |
| rnd_mode | input | 2 | Rounding mode (00 even, 01 up, 10 down, 11 zero) |
| feat_en | input | 1 | Feature enable; low makes any instruction illegal |
| rf_we | input | 1 | External register write enable |
| rf_waddr | input | 5 | External write register index |
| rf_wdata | input | VLEN | External write data |
| rf_raddr | input | 5 | External read register index |
| rf_rdata | output | VLEN | Contents of the addressed register |
| busy | output | 1 | Conversion or writeback in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | With `done`: the instruction was undefined |

## Verification
The bench goes after rounding boundaries: halfway values just above 2^24, the largest input 32'hFFFFFFFF, and values near the top binade where rounding carries into the exponent. A converter with the wrong tie rule or without carry propagation gives results one unit off or a wrong exponent. It runs conversions whose destination group equals the source group, where a unit that writes back before converting everything would feed converted values into later lanes. It also changes the rounding input and the instruction word mid-run, and issues disabled and malformed encodings. A unit that samples late, re-accepts while busy, or writes registers on an illegal instruction would leave register contents that differ from the bench's shadow copy.

// File: rtl/ucvt_pkg.sv
package ucvt_pkg;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned NUM_VREGS = 32;
  localparam int unsigned ELEM_W    = 32;
  localparam int unsigned MAX_GROUP = 4;
  localparam int unsigned GRP_IDX_W = 2;

  localparam logic [21:0] OPC_PAIR = 22'b1100000100100010111000;
  localparam logic [21:0] OPC_QUAD = 22'b1100000100110010111000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CONV = 2'b01,
    ST_WB   = 2'b10,
    ST_DONE = 2'b11
  } ucvt_state_e;

  typedef enum logic [1:0] {
    RM_NEAREST_EVEN = 2'b00,
    RM_TO_POS       = 2'b01,
    RM_TO_NEG       = 2'b10,
    RM_TO_ZERO      = 2'b11
  } rmode_e;

  typedef struct packed {
    logic                 legal;
    logic                 quad;
    logic [REG_IDX_W-1:0] src_base;
    logic [REG_IDX_W-1:0] dst_base;
  } ucvt_dec_t;
endpackage

// File: rtl/ucvt_decode.sv
module ucvt_decode
  import ucvt_pkg::*;
(
  input  logic [31:0] instr,
  input  logic        feat_en,
  output ucvt_dec_t   dec
);
  logic pair_hit;
  logic quad_hit;

  always_comb begin
    pair_hit = (instr[31:10] == OPC_PAIR) && instr[5] && !instr[0];
    quad_hit = (instr[31:10] == OPC_QUAD) && (instr[6:5] == 2'b01) &&
               (instr[1:0] == 2'b00);
    dec.legal    = feat_en && (pair_hit || quad_hit);
    dec.quad     = quad_hit;
    if (quad_hit) begin
      dec.src_base = {instr[9:7], 2'b00};
      dec.dst_base = {instr[4:2], 2'b00};
    end else begin
      dec.src_base = {instr[9:6], 1'b0};
      dec.dst_base = {instr[4:1], 1'b0};
    end
  end
endmodule

// File: rtl/u32_to_f32.sv
module u32_to_f32
  import ucvt_pkg::*;
(
  input  logic [31:0] val,
  input  rmode_e      rm,
  output logic [31:0] fp
);
  logic [4:0]  lz;
  logic        hit;
  logic [31:0] norm;
  logic [22:0] frac;
  logic        guard;
  logic        sticky;
  logic        inc;
  logic [7:0]  bexp;

  always_comb begin
    lz  = '0;
    hit = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!hit && val[i]) begin
        lz  = 5'(31 - i);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    norm   = val << lz;
    frac   = norm[30:8];
    guard  = norm[7];
    sticky = |norm[6:0];
    bexp   = 8'd158 - {3'b000, lz};
    unique case (rm)
      RM_NEAREST_EVEN: inc = guard && (sticky || frac[0]);
      RM_TO_POS:       inc = guard || sticky;
      default:         inc = 1'b0;
    endcase
    if (val == 32'd0) fp = 32'd0;
    else              fp = {1'b0, bexp, frac} + {31'd0, inc};
  end
endmodule

// File: rtl/ucvt_vrf.sv
module ucvt_vrf
  import ucvt_pkg::*;
#(
  parameter int unsigned VLEN  = 128,
  parameter int unsigned NREGS = NUM_VREGS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_IDX_W-1:0] waddr,
  input  logic [VLEN-1:0]      wdata,
  input  logic [REG_IDX_W-1:0] raddr_a,
  output logic [VLEN-1:0]      rdata_a,
  input  logic [REG_IDX_W-1:0] raddr_b,
  output logic [VLEN-1:0]      rdata_b
);
  logic [VLEN-1:0] mem_q [NREGS];

  for (genvar r = 0; r < NREGS; r++) begin : g_row
    logic row_en;
    assign row_en = we && (waddr == REG_IDX_W'(r));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mem_q[r] <= '0;
      else if (row_en) mem_q[r] <= wdata;
    end
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/ucvt_group_unit.sv
module ucvt_group_unit
  import ucvt_pkg::*;
#(
  parameter int unsigned VLEN = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [31:0]          instr,
  input  logic [1:0]           rnd_mode,
  input  logic                 feat_en,
  input  logic                 rf_we,
  input  logic [REG_IDX_W-1:0] rf_waddr,
  input  logic [VLEN-1:0]      rf_wdata,
  input  logic [REG_IDX_W-1:0] rf_raddr,
  output logic [VLEN-1:0]      rf_rdata,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal
);
  localparam int unsigned LANES  = VLEN / ELEM_W;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned CNT_W  = LANE_W + GRP_IDX_W;
  localparam logic [CNT_W-1:0] LAST_PAIR = CNT_W'(2 * LANES - 1);
  localparam logic [CNT_W-1:0] LAST_QUAD = CNT_W'(4 * LANES - 1);

  ucvt_state_e          state_q, state_d;
  ucvt_dec_t            dec_now, dec_q, dec_d;
  rmode_e               rm_q, rm_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic [GRP_IDX_W-1:0] wb_q, wb_d;
  logic                 ill_q, ill_d;

  logic [LANE_W-1:0]    cur_lane;
  logic [GRP_IDX_W-1:0] cur_reg;
  logic [CNT_W-1:0]     last_cnt;
  logic [GRP_IDX_W-1:0] last_reg;
  logic                 buf_we;
  logic                 wb_we;
  logic [31:0]          lane_word;
  logic [31:0]          conv_out;
  logic [VLEN-1:0]      src_vec;
  logic [VLEN-1:0]      res_rows [MAX_GROUP];

  logic                 vrf_we;
  logic [REG_IDX_W-1:0] vrf_waddr;
  logic [VLEN-1:0]      vrf_wdata;
  logic [REG_IDX_W-1:0] src_addr;

  ucvt_decode u_dec (
    .instr   (instr),
    .feat_en (feat_en),
    .dec     (dec_now)
  );

  // Lane and register position inside the group
  assign cur_lane = cnt_q[LANE_W-1:0];
  assign cur_reg  = cnt_q[CNT_W-1 -: GRP_IDX_W];
  assign last_cnt = dec_q.quad ? LAST_QUAD : LAST_PAIR;
  assign last_reg = dec_q.quad ? 2'd3 : 2'd1;

  assign busy    = (state_q == ST_CONV) || (state_q == ST_WB);
  assign done    = (state_q == ST_DONE);
  assign illegal = done && ill_q;
  assign buf_we  = (state_q == ST_CONV);
  assign wb_we   = (state_q == ST_WB);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    dec_d   = dec_q;
    rm_d    = rm_q;
    cnt_d   = cnt_q;
    wb_d    = wb_q;
    ill_d   = ill_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          ill_d = !dec_now.legal;
          if (dec_now.legal) begin
            dec_d   = dec_now;
            rm_d    = rmode_e'(rnd_mode);
            cnt_d   = '0;
            state_d = ST_CONV;
          end else begin
            state_d = ST_DONE;
          end
        end
      end
      ST_CONV: begin
        if (cnt_q == last_cnt) begin
          wb_d    = '0;
          state_d = ST_WB;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WB: begin
        if (wb_q == last_reg) state_d = ST_DONE;
        else                  wb_d    = wb_q + GRP_IDX_W'(1);
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      dec_q   <= '0;
      rm_q    <= RM_NEAREST_EVEN;
      cnt_q   <= '0;
      wb_q    <= '0;
      ill_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dec_q   <= dec_d;
      rm_q    <= rm_d;
      cnt_q   <= cnt_d;
      wb_q    <= wb_d;
      ill_q   <= ill_d;
    end
  end

  // Source lane fetch and conversion
  assign src_addr  = dec_q.src_base + REG_IDX_W'(cur_reg);
  assign lane_word = src_vec[ELEM_W*cur_lane +: ELEM_W];

  u32_to_f32 u_cvt (
    .val (lane_word),
    .rm  (rm_q),
    .fp  (conv_out)
  );

  // Result buffer: one row per group member, filled lane by lane
  for (genvar g = 0; g < MAX_GROUP; g++) begin : g_buf
    logic            row_en;
    logic [VLEN-1:0] row_q;
    assign row_en = buf_we && (cur_reg == GRP_IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_en) row_q[ELEM_W*cur_lane +: ELEM_W] <= conv_out;
    end
    assign res_rows[g] = row_q;
  end

  // Register file write selection: writeback has the port while busy
  always_comb begin
    if (wb_we) begin
      vrf_we    = 1'b1;
      vrf_waddr = dec_q.dst_base + REG_IDX_W'(wb_q);
      vrf_wdata = res_rows[wb_q];
    end else begin
      vrf_we    = rf_we && !busy;
      vrf_waddr = rf_waddr;
      vrf_wdata = rf_wdata;
    end
  end

  ucvt_vrf #(
    .VLEN  (VLEN),
    .NREGS (NUM_VREGS)
  ) u_vrf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (vrf_we),
    .waddr   (vrf_waddr),
    .wdata   (vrf_wdata),
    .raddr_a (rf_raddr),
    .rdata_a (rf_rdata),
    .raddr_b (src_addr),
    .rdata_b (src_vec)
  );
endmodule

// File: rtl/ucvt_checker.sv
module ucvt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        illegal,
  input logic        wb_we,
  input logic [31:0] conv_in,
  input logic [31:0] conv_out
);
  // R10: completion is a single-cycle pulse
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: busy and done never overlap
  p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R10: work begins only after an offered start
  p_busy_needs_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R8: the illegal flag only accompanies completion
  p_illegal_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done);

  // R9: an illegal completion is not preceded by a writeback cycle
  p_illegal_no_wb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !$past(wb_we));

  // R11: writeback only happens while busy
  p_wb_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_we |-> busy);

  // R3: unsigned inputs never produce a negative result
  p_sign_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !conv_out[31]);

  // R3: zero maps to positive zero
  p_zero_maps_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_in == 32'd0) |-> (conv_out == 32'd0));
endmodule

bind ucvt_group_unit ucvt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .illegal  (illegal),
  .wb_we    (wb_we),
  .conv_in  (lane_word),
  .conv_out (conv_out)
);

// File: tb/tb_ucvt_group_unit.sv
module tb_ucvt_group_unit;
  localparam int VLEN  = 128;
  localparam int LANES = VLEN / 32;
  localparam int NR    = 32;

  logic            clk;
  logic            rst_n;
  logic            start;
  logic [31:0]     instr;
  logic [1:0]      rnd_mode;
  logic            feat_en;
  logic            rf_we;
  logic [4:0]      rf_waddr;
  logic [VLEN-1:0] rf_wdata;
  logic [4:0]      rf_raddr;
  logic [VLEN-1:0] rf_rdata;
  logic            busy;
  logic            done;
  logic            illegal;

  int checks = 0;
  int fails  = 0;
  logic [VLEN-1:0] model [NR];

  ucvt_group_unit #(.VLEN(VLEN)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .rnd_mode(rnd_mode), .feat_en(feat_en), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .rf_raddr(rf_raddr),
    .rf_rdata(rf_rdata), .busy(busy), .done(done), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string what,
                       input logic [VLEN-1:0] act, input logic [VLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Reference conversion by exact integer arithmetic (R3, R4)
  function automatic logic [31:0] ref_cvt(input logic [31:0] x, input logic [1:0] rm);
    int p;
    int sh;
    logic [63:0] t, rem, half;
    logic inc;
    if (x == 32'd0) return 32'd0;
    p = 31;
    while (!x[p]) p--;
    if (p <= 23) return 32'((127 + p) << 23) | ((x << (23 - p)) & 32'h007FFFFF);
    sh   = p - 23;
    t    = 64'(x) >> sh;
    rem  = 64'(x) - (t << sh);
    half = 64'd1 << (sh - 1);
    case (rm)
      2'b00:   inc = (rem > half) || ((rem == half) && t[0]);
      2'b01:   inc = (rem != 0);
      default: inc = 1'b0;
    endcase
    return 32'((127 + p) << 23) + 32'(t - 64'h800000) + 32'(inc);
  endfunction

  // Bench-side decode from the encodings in R1, R2, R8, R9
  task automatic bdec(input logic [31:0] ins, input logic fe,
                      output bit ok, output int n, output int s, output int d);
    ok = 0; n = 0; s = 0; d = 0;
    if (ins[31:10] == 22'b1100000100100010111000 && ins[5] && !ins[0]) begin
      ok = 1; n = 2; s = int'(ins[9:6]) * 2; d = int'(ins[4:1]) * 2;
    end else if (ins[31:10] == 22'b1100000100110010111000 && ins[6:5] == 2'b01 &&
                 ins[1:0] == 2'b00) begin
      ok = 1; n = 4; s = int'(ins[9:7]) * 4; d = int'(ins[4:2]) * 4;
    end
    if (!fe) ok = 0;
  endtask

  function automatic logic [31:0] mk_pair(input int sf, input int df);
    return {22'b1100000100100010111000, 4'(sf), 1'b1, 4'(df), 1'b0};
  endfunction
  function automatic logic [31:0] mk_quad(input int sf, input int df);
    return {22'b1100000100110010111000, 3'(sf), 2'b01, 3'(df), 2'b00};
  endfunction

  function automatic logic [31:0] pick_word();
    case ($urandom % 8)
      0: return 32'd0;
      1: return 32'hFFFFFFFF;
      2: return 32'd1 << ($urandom % 32);
      3: return 32'h01000001 << ($urandom % 8);
      4: return 32'h00FFFFFF;
      5: return 32'hFFFFFF80;
      default: return $urandom;
    endcase
  endfunction

  task automatic load_reg(input int idx, input logic [VLEN-1:0] data);
    @(negedge clk);
    rf_we = 1'b1; rf_waddr = 5'(idx); rf_wdata = data;
    @(negedge clk);
    rf_we = 1'b0;
    model[idx] = data;
  endtask

  // R11: compare every register with the shadow copy
  task automatic check_all(input string tag);
    for (int i = 0; i < NR; i++) begin
      rf_raddr = 5'(i);
      #1;
      check(rf_rdata === model[i], $sformatf("%s reg %0d", tag, i), rf_rdata, model[i]);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [1:0] rm, input logic fe,
                     input bit hold, input string tag);
    bit ok;
    int n, s, d, cyc;
    logic [VLEN-1:0] tmp [4];
    bdec(ins, fe, ok, n, s, d);
    if (ok) begin
      // R7: all results from the original sources, then written
      for (int r = 0; r < n; r++)
        for (int e = 0; e < LANES; e++)
          tmp[r][32*e +: 32] = ref_cvt(model[s + r][32*e +: 32], rm);
      for (int r = 0; r < n; r++) model[d + r] = tmp[r];
    end
    @(negedge clk);
    instr = ins; rnd_mode = rm; feat_en = fe; start = 1'b1;
    @(negedge clk);
    // R5: rounding input changes while busy; R10: start/instr ignored while busy
    rnd_mode = ~rm;
    if (hold) instr = 32'h0;
    else      start = 1'b0;
    // R11: external write attempt while busy must be dropped
    if (ok) begin
      rf_we = 1'b1; rf_waddr = 5'($urandom % NR); rf_wdata = {VLEN{1'b1}};
    end
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      rf_we = 1'b0;
      cyc++;
    end
    rf_we = 1'b0;
    start = 1'b0;
    check(illegal == !ok, {tag, " R8/R9 illegal flag"}, VLEN'(illegal), VLEN'(!ok));
    check(cyc == (ok ? n * LANES + n : 0), {tag, " R10 latency"}, VLEN'(cyc),
          VLEN'(ok ? n * LANES + n : 0));
    @(negedge clk);
    check(!done && !busy, {tag, " R10 done pulse width"}, VLEN'({done, busy}), '0);
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; instr = '0; rnd_mode = '0; feat_en = 1'b1;
    rf_we = 1'b0; rf_waddr = '0; rf_wdata = '0; rf_raddr = '0;
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !illegal, "R10 reset outputs", VLEN'({busy, done, illegal}), '0);
    check_all("R10 reset regs");

    // Directed corner lanes
    load_reg(0, {32'h01000000, 32'h00FFFFFF, 32'h00000001, 32'h00000000});
    load_reg(1, {32'h80000000, 32'hFFFFFFFF, 32'h01000003, 32'h01000001});
    load_reg(2, {32'h12345678, 32'h00000003, 32'h01000002, 32'h7FFFFFFF});
    load_reg(3, {32'h00000003, 32'h00000100, 32'hFFFFFF7F, 32'hFFFFFF80});
    for (int i = 4; i < NR; i++)
      load_reg(i, {pick_word(), pick_word(), pick_word(), pick_word()});

    // R1, R2, R3, R4, R6 across every rounding mode
    for (int m = 0; m < 4; m++) begin
      run(mk_pair(0, 5), 2'(m), 1'b1, 1'b0, "R1/R3/R4/R6 pair");
      run(mk_quad(0, 3), 2'(m), 1'b1, 1'b0, "R2/R3/R4/R5 quad");
    end

    // R7: destination group equals source group
    run(mk_quad(1, 1), 2'b00, 1'b1, 1'b0, "R7 quad overlap");
    run(mk_pair(4, 4), 2'b01, 1'b1, 1'b0, "R7 pair overlap");

    // R8: disabled feature
    run(mk_quad(0, 2), 2'b00, 1'b0, 1'b0, "R8 disabled");
    // R9: malformed encodings
    run(mk_pair(0, 2) | 32'h1, 2'b00, 1'b1, 1'b0, "R9 bad bit0");
    run(mk_quad(0, 2) ^ 32'h20, 2'b00, 1'b1, 1'b0, "R9 bad size bits");
    run(32'hDEADBEEF, 2'b11, 1'b1, 1'b0, "R9 garbage");

    // R10: start held high and instr changed to illegal during the run
    run(mk_pair(3, 9), 2'b10, 1'b1, 1'b1, "R10 held start");

    // Constrained random mix
    for (int it = 0; it < 40; it++) begin
      logic [31:0] ins;
      for (int k = 0; k < 3; k++)
        load_reg(int'($urandom % NR), {pick_word(), pick_word(), pick_word(), pick_word()});
      case ($urandom % 5)
        0, 1: ins = mk_pair(int'($urandom % 16), int'($urandom % 16));
        2, 3: ins = mk_quad(int'($urandom % 8), int'($urandom % 8));
        default: ins = $urandom;
      endcase
      run(ins, 2'($urandom % 4), ($urandom % 10) != 0, ($urandom % 4) == 0,
          "R1/R2/R4/R6/R9/R11 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule